// File: doc/BRIEF.md
# Dual-bus masked match event counter

This block is a passive debug monitor that sits beside two data buses and tallies how often each one carries a value of interest. Each bus has its own compare pattern and its own care mask. A bus is said to hit in a cycle when every bit position selected by its care mask equals the pattern, and positions left out of the mask play no part. Three saturating counters record hits on the first bus, hits on the second bus, and cycles in which both buses hit together.

Software or a debug controller loads the patterns and masks through four write strobes that share one data input, and zeroes all three counters with a clear strobe. Counting takes place only while the enable input is high. Results are read directly from the count outputs. Everything is sampled on the rising clock edge, so a hit shows up in the counts one cycle after the data that caused it.

Top module: `dual_bus_match_counter`

## Requirements
- R1: After reset all three counts read 0, and both patterns and both care masks are 0, which means every bit is a don't-care.
- R2: In each cycle with count_en high and cnt_clear low, cnt_a rises by one when ((bus_a XOR pattern A) AND care mask A) is 0, and holds otherwise.
- R3: cnt_b follows the same rule using bus_b, pattern B and care mask B, independently of bus A.
- R4: cnt_both rises by one only in cycles in which both bus_a and bus_b hit; a cycle in which only one bus hits leaves cnt_both unchanged.
- R5: A care mask bit of 0 makes that bit position a don't-care: changing the bus value in that position never alters whether the bus hits.
- R6: While count_en is low, none of the three counts change.
- R7: A cycle with cnt_clear high sets all three counts to 0 at the next edge, taking priority over any increment in that cycle.
- R8: A count that has reached its all-ones value stays there on further hits instead of wrapping.
- R9: A hit at a rising edge appears on the count outputs after that edge; a value written through cfg_wr_pat_a, cfg_wr_care_a, cfg_wr_pat_b or cfg_wr_care_b from cfg_data is used for comparisons from the following cycle on, and the comparison in the writing cycle still uses the old value.
- R10: Each of the four configuration strobes writes only its own register, so the two buses can watch different patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_en | input | 1 | Counting enable |
| bus_a | input | W | First observed bus |
| bus_b | input | W | Second observed bus |
| cfg_data | input | W | Configuration write data |
| cfg_wr_pat_a | input | 1 | Load pattern A from cfg_data |
| cfg_wr_care_a | input | 1 | Load care mask A from cfg_data |
| cfg_wr_pat_b | input | 1 | Load pattern B from cfg_data |
| cfg_wr_care_b | input | 1 | Load care mask B from cfg_data |
| cnt_clear | input | 1 | Synchronous clear of all counts |
| cnt_a | output | CW | Hit count for bus A |
| cnt_b | output | CW | Hit count for bus B |
| cnt_both | output | CW | Count of cycles where both buses hit |

## Verification
The hardest state to reach from the ports is a saturated counter, since the default width would need billions of hits; the bench instantiates the block with narrow counters and drives long runs with all-don't-care masks so every count reaches all ones and is then pushed further. A second awkward corner is a configuration write landing in a cycle whose bus value matches only one of the old and new patterns, which the stimulus sets up deliberately to show that the old value governs that cycle. Clear is also raised in hit cycles so that its priority over increment is visible.

// File: rtl/dual_bus_match_counter.sv
module dual_bus_match_counter #(
  parameter int W  = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic [W-1:0]  bus_a,
  input  logic [W-1:0]  bus_b,
  input  logic [W-1:0]  cfg_data,
  input  logic          cfg_wr_pat_a,
  input  logic          cfg_wr_care_a,
  input  logic          cfg_wr_pat_b,
  input  logic          cfg_wr_care_b,
  input  logic          cnt_clear,
  output logic [CW-1:0] cnt_a,
  output logic [CW-1:0] cnt_b,
  output logic [CW-1:0] cnt_both
);

  localparam logic [CW-1:0] CNT_TOP = '1;

  logic [W-1:0]  pat_a_q, care_a_q, pat_b_q, care_b_q;
  logic          hit_a, hit_b;
  logic [CW-1:0] cnt_a_q, cnt_b_q, cnt_both_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_a_q  <= '0;
      care_a_q <= '0;
      pat_b_q  <= '0;
      care_b_q <= '0;
    end else begin
      if (cfg_wr_pat_a)  pat_a_q  <= cfg_data;
      if (cfg_wr_care_a) care_a_q <= cfg_data;
      if (cfg_wr_pat_b)  pat_b_q  <= cfg_data;
      if (cfg_wr_care_b) care_b_q <= cfg_data;
    end
  end

  assign hit_a = ~|((bus_a ^ pat_a_q) & care_a_q);
  assign hit_b = ~|((bus_b ^ pat_b_q) & care_b_q);

  function automatic logic [CW-1:0] bump(input logic [CW-1:0] c, input logic inc);
    return (inc && c != CNT_TOP) ? c + 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a_q    <= '0;
      cnt_b_q    <= '0;
      cnt_both_q <= '0;
    end else if (cnt_clear) begin
      cnt_a_q    <= '0;
      cnt_b_q    <= '0;
      cnt_both_q <= '0;
    end else if (count_en) begin
      cnt_a_q    <= bump(cnt_a_q, hit_a);
      cnt_b_q    <= bump(cnt_b_q, hit_b);
      cnt_both_q <= bump(cnt_both_q, hit_a & hit_b);
    end
  end

  assign cnt_a    = cnt_a_q;
  assign cnt_b    = cnt_b_q;
  assign cnt_both = cnt_both_q;

endmodule

// File: rtl/dual_bus_match_counter_chk.sv
module dual_bus_match_counter_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          count_en,
  input logic          cnt_clear,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] cnt_both
);

  localparam logic [CW-1:0] TOP = '1;

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (cnt_a == '0 && cnt_b == '0 && cnt_both == '0));

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_en && !cnt_clear) |=> ($stable(cnt_a) && $stable(cnt_b) && $stable(cnt_both)));

  p_step_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (cnt_a == $past(cnt_a) || cnt_a == $past(cnt_a) + 1'b1));

  p_step_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (cnt_b == $past(cnt_b) || cnt_b == $past(cnt_b) + 1'b1));

  p_both_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_both <= cnt_a && cnt_both <= cnt_b));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_a == TOP && !cnt_clear) |=> cnt_a == TOP);

endmodule

bind dual_bus_match_counter dual_bus_match_counter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_en(count_en), .cnt_clear(cnt_clear),
  .cnt_a(cnt_a), .cnt_b(cnt_b), .cnt_both(cnt_both)
);

// File: tb/test_dual_bus_match_counter.sv
module test_dual_bus_match_counter;
  localparam int W = 16;
  localparam int CW = 8;
  localparam logic [CW-1:0] TOP = '1;

  logic clk = 0, rst_n = 0, count_en = 0, cnt_clear = 0;
  logic [W-1:0] bus_a = '0, bus_b = '0, cfg_data = '0;
  logic cfg_wr_pat_a = 0, cfg_wr_care_a = 0, cfg_wr_pat_b = 0, cfg_wr_care_b = 0;
  logic [CW-1:0] cnt_a, cnt_b, cnt_both;

  always #2 clk = ~clk;

  dual_bus_match_counter #(.W(W), .CW(CW)) i_dual_bus_match_counter (.*);

  typedef struct { logic [CW-1:0] a, b, both; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_pa = '0, m_ca = '0, m_pb = '0, m_cb = '0;
  logic [CW-1:0] m_a = '0, m_b = '0, m_both = '0;

  function automatic logic [CW-1:0] inc(input logic [CW-1:0] c, input logic h);
    return (h && c != TOP) ? c + 1'b1 : c;
  endfunction

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic en,
                      input logic clr, input logic [3:0] wr, input logic [W-1:0] d,
                      input string tag);
    logic ha, hb;
    exp_t e;
    @(negedge clk);
    bus_a = a; bus_b = b; count_en = en; cnt_clear = clr; cfg_data = d;
    {cfg_wr_pat_a, cfg_wr_care_a, cfg_wr_pat_b, cfg_wr_care_b} = wr;
    ha = ((a ^ m_pa) & m_ca) == '0;
    hb = ((b ^ m_pb) & m_cb) == '0;
    if (clr) begin m_a = '0; m_b = '0; m_both = '0; end
    else if (en) begin m_a = inc(m_a, ha); m_b = inc(m_b, hb); m_both = inc(m_both, ha & hb); end
    if (wr[3]) m_pa = d;
    if (wr[2]) m_ca = d;
    if (wr[1]) m_pb = d;
    if (wr[0]) m_cb = d;
    e.a = m_a; e.b = m_b; e.both = m_both; e.tag = tag;
    sb.push_back(e);
  endtask

  always begin
    @(posedge clk); #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cnt_a !== e.a || cnt_b !== e.b || cnt_both !== e.both) begin
        fails++;
        $display("FAIL %s: got a=%0d b=%0d both=%0d expected a=%0d b=%0d both=%0d",
                 e.tag, cnt_a, cnt_b, cnt_both, e.a, e.b, e.both);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cnt_a !== 0 || cnt_b !== 0 || cnt_both !== 0) begin
      fails++;
      $display("FAIL R1 reset: got a=%0d b=%0d both=%0d expected 0 0 0", cnt_a, cnt_b, cnt_both);
    end
    rst_n = 1;
    // R1: reset masks are all don't-care, so any data hits
    step(16'h1234, 16'h9999, 1, 0, 4'b0000, 0, "R1 all-dont-care after reset");
    step(16'h0000, 16'hFFFF, 1, 0, 4'b0000, 0, "R1 all-dont-care after reset");
    step(0, 0, 0, 1, 4'b0000, 0, "R7 clear");
    // R10: configure each register separately
    step(0, 0, 0, 0, 4'b1000, 16'hA5C3, "R10 write pattern A");
    step(0, 0, 0, 0, 4'b0100, 16'hFFFF, "R10 write care A");
    step(0, 0, 0, 0, 4'b0010, 16'h3C00, "R10 write pattern B");
    step(0, 0, 0, 0, 4'b0001, 16'hFF00, "R10 write care B");
    step(16'hA5C3, 16'h1111, 1, 0, 0, 0, "R2 A hit only");
    step(16'hA5C2, 16'h3C00, 1, 0, 0, 0, "R3 B hit only");
    step(16'hA5C3, 16'h3CAB, 1, 0, 0, 0, "R4 both hit, R5 low byte B ignored");
    step(16'hA5C3, 16'h3D00, 1, 0, 0, 0, "R4 one miss no both");
    step(16'hA5C3, 16'h3C5A, 0, 0, 0, 0, "R6 disabled");
    step(16'hA5C3, 16'h3C00, 0, 0, 0, 0, "R6 disabled");
    step(16'hA5C3, 16'h3CFF, 1, 1, 0, 0, "R7 clear beats hit");
    // R9: write in a hitting cycle, old pattern still governs that cycle
    step(16'hA5C3, 16'h3C00, 1, 0, 4'b1000, 16'h0F0F, "R9 old pattern used in write cycle");
    step(16'hA5C3, 16'h3C00, 1, 0, 0, 0, "R9 new pattern from next cycle");
    step(16'h0F0F, 16'h3C00, 1, 0, 4'b0100, 16'h00F0, "R9 care write");
    step(16'hFF0F, 16'h3C77, 1, 0, 0, 0, "R5 masked bits ignored");
    step(16'hFFFF, 16'h3C77, 1, 0, 0, 0, "R5 cared bit mismatch");
    // mixed random traffic
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (i % 3 == 0) ra = (ra & ~m_ca) | (m_pa & m_ca);
      if (i % 4 == 0) rb = (rb & ~m_cb) | (m_pb & m_cb);
      step(ra, rb, (i % 7) != 0, (i % 53) == 52, 0, 0, "R2 R3 R4 mixed traffic");
    end
    // R8: saturation with everything don't-care
    step(0, 0, 0, 1, 4'b0101, 16'h0000, "R8 prepare");
    for (int i = 0; i < 270; i++)
      step($urandom, $urandom, 1, 0, 0, 0, "R8 saturation");
    step(0, 0, 1, 1, 0, 0, "R7 clear from saturation");
    step(0, 0, 1, 0, 0, 0, "R2 count after clear");
    step(0, 0, 0, 0, 0, 0, "idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule